// File: doc/BRIEF.md
# Multi-Lane Double-Edge Word Deserializer

This block rebuilds parallel words from up to four serial data lanes. The lanes are driven from a forwarded clock on both edges. Input capture cells, which are outside this block, deliver one bit pair per lane on every cycle of the core clock. One bit is taken on the rising half and one on the falling half, and the rising-half bit is the earlier of the two in the stream. Bits arrive most significant first, so the deserializer shifts each pair into a per-lane register. When the configured word width is reached, it releases the word on every active lane together.

A start-of-word pulse sets word alignment. The pulse has a qualifier that says whether the word begins on the rising-half bit or the falling-half bit of that cycle. After the pulse, words follow each other with no gaps. With an odd width, a word can end on a rising-half bit, and the falling-half bit of that cycle then becomes the first bit of the next word. The number of active lanes (2, 3 or 4) and the word width (12 to 20 bits) are run-time inputs.

Top module: `ddr_word_deser`

## Requirements
- R1: After reset, `word_valid` is 0 and every lane field of `word_o` is 0. No `word_valid` pulse occurs until the first `sow` pulse, whatever data is presented.
- R2: Each lane's word sits right-justified in its 20-bit field of `word_o` (lane k uses bits `[20k+19:20k]`). The first stream bit of a word lands in bit `width-1`, and every bit above `width-1` is 0.
- R3: Within one cycle, the `rise_in` bit comes before the `fall_in` bit in the stream, so it takes the higher bit position of the two.
- R4: When `sow` is 1 and `sow_fall` is 0, the word starts with that cycle's `rise_in` bit. When `sow_fall` is 1, that cycle's `rise_in` bit is dropped and the word starts with its `fall_in` bit.
- R5: When a word ends on a `rise_in` bit, the `fall_in` bit of the same cycle becomes bit `width-1` of the next word. Words follow back to back with no lost or repeated bits.
- R6: `word_valid` is a single-cycle pulse. It is high in the cycle right after the clock edge that samples the pair holding a word's last bit, and it covers all active lanes at once.
- R7: Lane k is active when k < n. Here n is `cfg_lanes` limited to the range 2 to 4: values below 2 act as 2 and values above 4 act as 4. The field of an inactive lane always reads 0.
- R8: The word width is `cfg_width` limited to the range 12 to 20: values below 12 act as 12 and values above 20 act as 20.
- R9: A `sow` pulse that arrives while a word is partly assembled discards the partial bits. No `word_valid` follows in the next cycle.
- R10: Between `word_valid` pulses, `word_o` holds the last completed words unchanged, provided `cfg_lanes` is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, one bit pair per lane per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| sow | input | 1 | Start-of-word pulse for all lanes |
| sow_fall | input | 1 | With `sow`: 1 = word starts on the falling-half bit |
| rise_in | input | 4 | Rising-half bit, one per lane |
| fall_in | input | 4 | Falling-half bit, one per lane |
| cfg_width | input | 5 | Word width in bits (limited to 12..20) |
| cfg_lanes | input | 3 | Active lane count (limited to 2..4) |
| word_valid | output | 1 | Pulse: new words present on active lanes |
| word_o | output | 80 | Four 20-bit lane fields, lane 0 lowest |

## Verification
The hardest case to reach from the ports is a word that ends on a rising-half bit, so that the falling-half bit of the same cycle has to start the next word. This happens only with odd widths, and on every second word. The bench uses a behavioural serializer to generate multi-word MSB-first streams for every width from 12 to 20 and every lane count, so each odd width produces this carry several times. The bench also runs streams that start on the falling half. It runs a stream with a deliberately interrupted early start, to show that partial words are discarded.

// File: rtl/ddrdes_pkg.sv
// Package ddrdes_pkg
// Shared types and helpers for the double-edge word deserializer.
// Assumes: callers pass limits with min <= max.
package ddrdes_pkg;

    // Per-cycle action that the controller broadcasts to every lane.
    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,  // not aligned yet, nothing shifts
        ACT_START_RF = 3'd1,  // new word starts with the rise bit
        ACT_START_F  = 3'd2,  // new word starts with the fall bit
        ACT_SHIFT2   = 3'd3,  // both bits join the current word
        ACT_END_F    = 3'd4,  // word completes on the fall bit
        ACT_END_R    = 3'd5   // word completes on the rise bit, fall bit carries
    } act_e;

    // Limit a requested value to [lo, hi].
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/ddrdes_cfg.sv
// Module ddrdes_cfg
// Turns the raw width and lane-count requests into an effective width
// and a per-lane enable mask. Out-of-range requests are clamped.
// Assumes: W_MIN <= W_MAX and N_LANES >= 2.
module ddrdes_cfg
    import ddrdes_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int W_MIN   = 12,
    parameter int W_MAX   = 20,
    parameter int WCW     = $clog2(W_MAX + 1),
    parameter int LCW     = $clog2(N_LANES + 1)
) (
    input  logic [WCW-1:0]     cfg_width,
    input  logic [LCW-1:0]     cfg_lanes,
    output logic [WCW-1:0]     eff_width,
    output logic [N_LANES-1:0] lane_en
);

    int eff_lanes;

    // Clamp the width and the lane count to their legal ranges.
    always_comb begin
        eff_width = WCW'(clamp_int(int'(cfg_width), W_MIN, W_MAX));
        eff_lanes = clamp_int(int'(cfg_lanes), 2, N_LANES);
    end

    // One enable per lane: lanes below the effective count are active.
    for (genvar k = 0; k < N_LANES; k++) begin : g_en
        assign lane_en[k] = (k < eff_lanes);
    end

endmodule

// File: rtl/ddrdes_ctrl.sv
// Module ddrdes_ctrl
// Shared bit counter. It decides, once per cycle, what every lane does
// with its rise/fall pair and produces the aligned word-valid pulse.
// Assumes: eff_width >= 3, so a word never completes on its start cycle,
// and the width is static while a word is being assembled.
module ddrdes_ctrl
    import ddrdes_pkg::*;
#(
    parameter int W_MAX = 20,
    parameter int WCW   = $clog2(W_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sow,
    input  logic           sow_fall,
    input  logic [WCW-1:0] eff_width,
    output act_e           act,
    output logic           word_valid,
    output logic           run_active
);

    logic [WCW-1:0] cnt_q;
    logic [WCW-1:0] cnt_d;
    logic           run_d;
    logic [WCW:0]   plus1;
    logic [WCW:0]   plus2;
    logic [WCW:0]   wid_x;

    // Choose this cycle's action and the next bit count.
    always_comb begin
        plus1 = {1'b0, cnt_q} + (WCW+1)'(1);
        plus2 = {1'b0, cnt_q} + (WCW+1)'(2);
        wid_x = {1'b0, eff_width};
        act   = ACT_HOLD;
        cnt_d = cnt_q;
        run_d = run_active;
        if (sow) begin
            run_d = 1'b1;
            if (sow_fall) begin
                act   = ACT_START_F;
                cnt_d = WCW'(1);
            end else begin
                act   = ACT_START_RF;
                cnt_d = WCW'(2);
            end
        end else if (run_active) begin
            if (plus1 >= wid_x) begin
                act   = ACT_END_R;
                cnt_d = WCW'(1);
            end else if (plus2 >= wid_x) begin
                act   = ACT_END_F;
                cnt_d = '0;
            end else begin
                act   = ACT_SHIFT2;
                cnt_d = plus2[WCW-1:0];
            end
        end
    end

    // Register the count, the aligned flag and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            run_active <= 1'b0;
            word_valid <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            run_active <= run_d;
            word_valid <= (act == ACT_END_F) || (act == ACT_END_R);
        end
    end

endmodule

// File: rtl/ddrdes_lane.sv
// Module ddrdes_lane
// One lane's shift register and word-holding register. It follows the
// action chosen by the controller. The held word is gated to zero when
// the lane is disabled.
// Assumes: W_MAX >= 3; the action sequence keeps the shifted bit count
// below the width in use.
module ddrdes_lane
    import ddrdes_pkg::*;
#(
    parameter int W_MAX = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic             rise_bit,
    input  logic             fall_bit,
    input  logic             lane_en,
    output logic [W_MAX-1:0] word
);

    logic [W_MAX-1:0] sh_q;
    logic [W_MAX-1:0] word_q;

    // Shift incoming bits MSB first and capture completed words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            word_q <= '0;
        end else begin
            unique case (act)
                ACT_START_RF: sh_q <= {{(W_MAX-2){1'b0}}, rise_bit, fall_bit};
                ACT_START_F:  sh_q <= {{(W_MAX-1){1'b0}}, fall_bit};
                ACT_SHIFT2:   sh_q <= {sh_q[W_MAX-3:0], rise_bit, fall_bit};
                ACT_END_F: begin
                    word_q <= {sh_q[W_MAX-3:0], rise_bit, fall_bit};
                    sh_q   <= '0;
                end
                ACT_END_R: begin
                    word_q <= {sh_q[W_MAX-2:0], rise_bit};
                    sh_q   <= {{(W_MAX-1){1'b0}}, fall_bit};
                end
                default: ;
            endcase
        end
    end

    // Disabled lanes present zero.
    assign word = lane_en ? word_q : '0;

endmodule

// File: rtl/ddr_word_deser.sv
// Module ddr_word_deser (top)
// Multi-lane deserializer for double-edge serial data. Each cycle it
// takes one rise/fall bit pair per lane and builds MSB-first words of a
// run-time width. All active lanes get a single aligned valid pulse.
// Assumes: lanes are already deskewed so that they share word alignment,
// the pair stream is continuous, and the configuration is changed only
// between words (a following sow re-aligns).
module ddr_word_deser
    import ddrdes_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int W_MIN   = 12,
    parameter int W_MAX   = 20,
    localparam int WCW    = $clog2(W_MAX + 1),
    localparam int LCW    = $clog2(N_LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sow,
    input  logic                     sow_fall,
    input  logic [N_LANES-1:0]       rise_in,
    input  logic [N_LANES-1:0]       fall_in,
    input  logic [WCW-1:0]           cfg_width,
    input  logic [LCW-1:0]           cfg_lanes,
    output logic                     word_valid,
    output logic [N_LANES*W_MAX-1:0] word_o
);

    logic [WCW-1:0]     eff_width;
    logic [N_LANES-1:0] lane_en;
    logic               run_active;
    act_e               act;

    ddrdes_cfg #(
        .N_LANES (N_LANES),
        .W_MIN   (W_MIN),
        .W_MAX   (W_MAX),
        .WCW     (WCW),
        .LCW     (LCW)
    ) u_cfg (
        .cfg_width (cfg_width),
        .cfg_lanes (cfg_lanes),
        .eff_width (eff_width),
        .lane_en   (lane_en)
    );

    ddrdes_ctrl #(
        .W_MAX (W_MAX),
        .WCW   (WCW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sow        (sow),
        .sow_fall   (sow_fall),
        .eff_width  (eff_width),
        .act        (act),
        .word_valid (word_valid),
        .run_active (run_active)
    );

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        ddrdes_lane #(
            .W_MAX (W_MAX)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (act),
            .rise_bit (rise_in[k]),
            .fall_bit (fall_in[k]),
            .lane_en  (lane_en[k]),
            .word     (word_o[k*W_MAX +: W_MAX])
        );
    end

endmodule

// File: rtl/ddr_word_deser_chk.sv
// Module ddr_word_deser_chk
// Property checker for ddr_word_deser, attached with bind. It checks the
// pulse shape, idle and restart behaviour, lane gating, the width bound
// and word holding.
// Assumes: reset is asserted from time zero.
module ddr_word_deser_chk
    import ddrdes_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int W_MIN   = 12,
    parameter int W_MAX   = 20,
    parameter int WCW     = $clog2(W_MAX + 1),
    parameter int LCW     = $clog2(N_LANES + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sow,
    input logic                     run_active,
    input logic                     word_valid,
    input logic [WCW-1:0]           cfg_width,
    input logic [LCW-1:0]           cfg_lanes,
    input logic [N_LANES*W_MAX-1:0] word_o
);

    int chk_lanes;
    int chk_width;

    // Independent view of the clamped configuration.
    always_comb begin
        chk_lanes = (int'(cfg_lanes) < 2) ? 2 :
                    (int'(cfg_lanes) > N_LANES) ? N_LANES : int'(cfg_lanes);
        chk_width = (int'(cfg_width) < W_MIN) ? W_MIN :
                    (int'(cfg_width) > W_MAX) ? W_MAX : int'(cfg_width);
    end

    // R6: the completion strobe never lasts two cycles
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R9: a restart is never followed directly by a completion
    p_sow_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sow |=> !word_valid);

    // R1: without alignment there is no completion
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !sow) |=> !word_valid);

    // R10: words hold between strobes
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_valid && $stable(cfg_lanes)) |-> $stable(word_o));

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane_chk
        // R7: lanes beyond the active count read zero
        p_inactive_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (k >= chk_lanes) |-> (word_o[k*W_MAX +: W_MAX] == '0));

        // R2: a fresh word has no bit above the width
        p_width_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (word_valid && (k < chk_lanes)) |->
            ((word_o[k*W_MAX +: W_MAX] >> chk_width) == '0));
    end

endmodule

bind ddr_word_deser ddr_word_deser_chk #(
    .N_LANES (N_LANES),
    .W_MIN   (W_MIN),
    .W_MAX   (W_MAX),
    .WCW     (WCW),
    .LCW     (LCW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sow        (sow),
    .run_active (run_active),
    .word_valid (word_valid),
    .cfg_width  (cfg_width),
    .cfg_lanes  (cfg_lanes),
    .word_o     (word_o)
);

// File: tb/ddr_word_deser_bench.sv
// Bench for ddr_word_deser. A behavioural serializer produces MSB-first
// streams as rise/fall pairs. A negedge monitor compares every strobe
// against the expected words.
module ddr_word_deser_bench;

    localparam int NL  = 4;
    localparam int WMX = 20;
    localparam int WMN = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sow = 1'b0;
    logic            sow_fall = 1'b0;
    logic [NL-1:0]   rise_in = '0;
    logic [NL-1:0]   fall_in = '0;
    logic [4:0]      cfg_width = 5'd20;
    logic [2:0]      cfg_lanes = 3'd4;
    logic            word_valid;
    logic [NL*WMX-1:0] word_o;

    int checks = 0;
    int fails  = 0;
    int exp_l, exp_w, exp_n, rx_n;
    logic [WMX-1:0] exp_word [NL][4];
    logic [NL-1:0]  sbits [0:127];
    bit   mon_on = 1'b0;
    string cur_tag = "";

    always #10 clk = ~clk;

    ddr_word_deser u_ddr_word_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sow        (sow),
        .sow_fall   (sow_fall),
        .rise_in    (rise_in),
        .fall_in    (fall_in),
        .cfg_width  (cfg_width),
        .cfg_lanes  (cfg_lanes),
        .word_valid (word_valid),
        .word_o     (word_o)
    );

    // Monitor: each strobe is one check of all lane fields.
    always @(negedge clk) begin
        if (mon_on && word_valid) begin
            checks++;
            if (rx_n >= exp_n) begin
                fails++;
                $display("FAIL %s R6 unexpected strobe: got index %0d expected count %0d",
                         cur_tag, rx_n, exp_n);
            end else begin
                for (int l = 0; l < NL; l++) begin
                    logic [WMX-1:0] e;
                    e = (l < exp_l) ? exp_word[l][rx_n] : '0;
                    if (word_o[l*WMX +: WMX] !== e) begin
                        fails++;
                        $display("FAIL %s R2 R3 R7 lane %0d word %0d: got %h expected %h",
                                 cur_tag, l, rx_n, word_o[l*WMX +: WMX], e);
                    end
                end
            end
            rx_n++;
        end
    end

    // Serialize words through the block and check count and holding.
    task automatic run_stream(input int lanes_cfg, input int width_cfg,
                              input int eff_l, input int eff_w, input int nwords,
                              input bit fall_start, input int junk_cycles,
                              input int seed, input string tag);
        int total, ncyc;
        cur_tag   = tag;
        cfg_lanes = 3'(lanes_cfg);
        cfg_width = 5'(width_cfg);
        exp_l = eff_l;
        exp_w = eff_w;
        exp_n = nwords;
        rx_n  = 0;
        for (int l = 0; l < NL; l++)
            for (int w = 0; w < nwords; w++)
                exp_word[l][w] = WMX'((seed * 613 + l * 1223 + w * 2719 + 77)
                                      & ((1 << eff_w) - 1));
        total = nwords * eff_w + int'(fall_start);
        ncyc  = (total + 1) / 2;
        for (int k = 0; k < 128; k++) begin
            for (int l = 0; l < NL; l++) begin
                if (k >= total || l >= eff_l || (fall_start && k == 0)) begin
                    sbits[k][l] = (((k * 7 + l * 3) % 5) < 2);
                end else begin
                    int b;
                    b = k - int'(fall_start);
                    sbits[k][l] = exp_word[l][b / eff_w][eff_w - 1 - (b % eff_w)];
                end
            end
        end
        mon_on = 1'b1;
        // Aborted early start (R9): sow followed by a few junk pairs.
        for (int j = 0; j < junk_cycles; j++) begin
            @(negedge clk);
            sow      = (j == 0);
            sow_fall = 1'b0;
            rise_in  = NL'(4'b1011 ^ j);
            fall_in  = NL'(4'b0110 ^ j);
        end
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            sow      = (c == 0);
            sow_fall = fall_start;
            rise_in  = sbits[2*c];
            fall_in  = sbits[2*c+1];
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sow     = 1'b0;
            rise_in = 4'b1010;
            fall_in = 4'b0101;
        end
        #1;
        checks++;
        if (rx_n != nwords) begin
            fails++;
            $display("FAIL %s R5 R6 strobe count: got %0d expected %0d", tag, rx_n, nwords);
        end
        // R10: the last words remain on the outputs after the strobe.
        checks++;
        for (int l = 0; l < eff_l; l++) begin
            if (word_o[l*WMX +: WMX] !== exp_word[l][nwords-1]) begin
                fails++;
                $display("FAIL %s R10 lane %0d held word: got %h expected %h",
                         tag, l, word_o[l*WMX +: WMX], exp_word[l][nwords-1]);
                break;
            end
        end
    endtask

    // Reset state and idle behaviour before any alignment (R1).
    task automatic test_reset();
        int bad;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (word_valid !== 1'b0 || word_o !== '0) begin
            fails++;
            $display("FAIL R1 reset state: got valid=%b word=%h expected 0 and 0", word_valid, word_o);
        end
        rst_n     = 1'b1;
        cfg_width = 5'd12;
        bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (word_valid !== 1'b0) bad++;
            rise_in = NL'(c * 5);
            fall_in = NL'(c * 3 + 1);
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R1 strobes before sow: got %0d expected 0", bad);
        end
    endtask

    // Every lane count against every width (R2 R3 R5 R6 R8).
    task automatic test_sweep();
        for (int ln = 2; ln <= NL; ln++)
            for (int w = WMN; w <= WMX; w++)
                run_stream(ln, w, ln, w, 3, 1'b0, 0, ln * 31 + w, "sweep");
    endtask

    // Words starting on the falling half (R4), including odd widths.
    task automatic test_fall_start();
        run_stream(4, 13, 4, 13, 3, 1'b1, 0, 5, "fall_start_R4");
        run_stream(3, 16, 3, 16, 3, 1'b1, 0, 9, "fall_start_R4");
    endtask

    // Restart in the middle of a word discards the partial bits (R9).
    task automatic test_restart();
        run_stream(4, 14, 4, 14, 2, 1'b0, 4, 21, "restart_R9");
        run_stream(2, 17, 2, 17, 2, 1'b1, 3, 22, "restart_R9");
    endtask

    // Out-of-range configuration is clamped (R7 R8).
    task automatic test_clamp();
        run_stream(7, 25, 4, 20, 2, 1'b0, 0, 40, "clamp_R7_R8");
        run_stream(1, 5, 2, 12, 2, 1'b0, 0, 41, "clamp_R7_R8");
        run_stream(0, 0, 2, 12, 2, 1'b1, 0, 42, "clamp_R7_R8");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_sweep();
        test_fall_start();
        test_restart();
        test_clamp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule